// File: doc/BRIEF.md
# Double-Precision Range Compare Unit

This unit compares two IEEE-754 double-precision operands and returns one of them as the result. A 4-bit control word picks one of four comparisons: smaller value, larger value, smaller magnitude or larger magnitude. The same control word then sets the sign of the result. The sign can come from the first operand, stay as the comparison produced it, or be forced clear or set. The unit also reports two flags, invalid and denormal. It does not trap.

The unit has a single register stage. Each operand is first classified as a number, a quiet NaN or a signalling NaN. When the flush input is high, a denormal operand is replaced by a zero with the same sign. A pick stage applies the fixed NaN rules and the tie rules for signed zeros and equal magnitudes. A sign stage then applies the sign control, except when the invalid flag is raised.

One common use is clamping. With control 0x2 and a second operand of +1023, the result is the first operand held within ±1023, and it keeps the sign of the first operand.

Top module: `fp_range_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result`, `flag_invalid` and `flag_denormal` are all zero.
- R2: The outputs for a vector presented with `in_valid` high appear after exactly one rising clock edge, with `out_valid` high. A cycle with `in_valid` low makes `out_valid` low and leaves `result` and both flags unchanged.
- R3: `ctl[1:0]` selects the comparison, using the signed value order in which a negative operand is below a positive one. The encodings are 00 smaller value, 01 larger value, 10 smaller magnitude and 11 larger magnitude. When the operands are identical, the first operand is returned.
- R4: `ctl[3:2]` selects the sign bit (bit W-1) of a non-invalid result. The encodings are 00 sign of `op_a`, 01 sign left as chosen, 10 sign forced to 0 and 11 sign forced to 1.
- R5: If either operand is a signalling NaN, the result is that operand made quiet, with `op_a` checked first. A NaN is signalling when its exponent is all ones, its mantissa is non-zero and mantissa bit MAN_W-1 is 0. Making it quiet sets mantissa bit MAN_W-1 and keeps every other bit. In this case `flag_invalid` is 1 and `ctl[3:2]` has no effect.
- R6: If neither operand is a signalling NaN, `flag_invalid` is 0. In this case:
  - If `op_a` is a quiet NaN and `op_b` is a number, the result is `op_b`.
  - If both operands are quiet NaNs, the result is `op_a`.
  - If `op_a` is a number and `op_b` is a quiet NaN, the result is `op_a`.
  - `ctl[3:2]` still applies to the result.
- R7: For zeros of opposite sign, in either order, the smaller-value and smaller-magnitude comparisons give -0, and the larger-value and larger-magnitude comparisons give +0.
- R8: For non-zero operands of equal magnitude and opposite sign, in either order, smaller-magnitude returns the negative operand and larger-magnitude returns the positive one.
- R9: When `daz` is high, a denormal operand (exponent zero, mantissa non-zero) is treated as a zero of the same sign, both in the comparison and in the result.
- R10: `flag_denormal` is 1 exactly when at least one input operand is denormal, whatever the value of `daz`.
- R11: With the default format, control 0x2 and `op_b` = +1023.0, the result is `op_a` when |op_a| < 1023. Otherwise it is 1023.0 carrying the sign of `op_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and control are valid this cycle |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| ctl | input | 4 | [1:0] comparison select, [3:2] sign select |
| daz | input | 1 | Treat denormal operands as zero |
| out_valid | output | 1 | Result registered from a valid input |
| result | output | 1+EXP_W+MAN_W | Selected operand with the chosen sign |
| flag_invalid | output | 1 | A signalling NaN was seen |
| flag_denormal | output | 1 | A denormal operand was seen |

## Verification
The main instance is built with EXP_W=3 and MAN_W=2, which gives a 6-bit format. In that format every operand pair, every one of the 16 control words and both `daz` settings can be swept. The sweep therefore reaches every NaN class pairing, every signed-zero and equal-magnitude tie, and every denormal case, and the bench predicts each one from integer magnitudes. A second instance with the default double-precision format checks the ±1023 clamp on real values.

// File: rtl/fp_range_pkg.sv
package fp_range_pkg;

    typedef enum logic [1:0] {
        OPC_NUM  = 2'd0,
        OPC_QNAN = 2'd1,
        OPC_SNAN = 2'd2
    } opclass_t;

    typedef enum logic [1:0] {
        CMP_MIN    = 2'd0,
        CMP_MAX    = 2'd1,
        CMP_MINMAG = 2'd2,
        CMP_MAXMAG = 2'd3
    } cmp_mode_t;

    typedef enum logic [1:0] {
        SGN_SRC1  = 2'd0,
        SGN_KEEP  = 2'd1,
        SGN_CLEAR = 2'd2,
        SGN_SET   = 2'd3
    } sign_mode_t;

endpackage

// File: rtl/fp_operand_prep.sv
module fp_operand_prep
    import fp_range_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] op,
    input  logic                 daz,
    output opclass_t             cls,
    output logic                 denorm,
    output logic [EXP_W+MAN_W:0] eff
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic exp_ones, exp_zero, man_nz;

    assign exp_ones = &op[W-2:MAN_W];
    assign exp_zero = ~|op[W-2:MAN_W];
    assign man_nz   = |op[MAN_W-1:0];
    assign denorm   = exp_zero & man_nz;

    always_comb begin
        if (exp_ones && man_nz)
            cls = op[MAN_W-1] ? OPC_QNAN : OPC_SNAN;
        else
            cls = OPC_NUM;
    end

    // Flush to a signed zero when requested
    assign eff = (daz && denorm) ? {op[W-1], {(W-1){1'b0}}} : op;

endmodule

// File: rtl/fp_range_pick.sv
module fp_range_pick
    import fp_range_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  opclass_t             cls_a,
    input  opclass_t             cls_b,
    input  cmp_mode_t            mode,
    output logic [EXP_W+MAN_W:0] value,
    output logic                 invalid
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);

    logic [W-2:0] mag_a, mag_b;
    logic         sa, sb, mag_lt, mag_gt, mag_eq;
    logic         a_below_b, b_below_a, take_b;

    assign mag_a  = a[W-2:0];
    assign mag_b  = b[W-2:0];
    assign sa     = a[W-1];
    assign sb     = b[W-1];
    assign mag_lt = mag_a < mag_b;
    assign mag_gt = mag_a > mag_b;
    assign mag_eq = mag_a == mag_b;

    // Signed order: negative below positive, -0 below +0
    always_comb begin
        if (sa != sb) begin
            a_below_b = sa;
            b_below_a = sb;
        end else if (sa) begin
            a_below_b = mag_gt;
            b_below_a = mag_lt;
        end else begin
            a_below_b = mag_lt;
            b_below_a = mag_gt;
        end
    end

    always_comb begin
        unique case (mode)
            CMP_MIN:    take_b = b_below_a;
            CMP_MAX:    take_b = a_below_b;
            CMP_MINMAG: take_b = mag_gt || (mag_eq && sb && !sa);
            CMP_MAXMAG: take_b = mag_lt || (mag_eq && sa && !sb);
            default:    take_b = 1'b0;
        endcase
    end

    always_comb begin
        invalid = 1'b0;
        if (cls_a == OPC_SNAN) begin
            value   = a | QUIET_BIT;
            invalid = 1'b1;
        end else if (cls_b == OPC_SNAN) begin
            value   = b | QUIET_BIT;
            invalid = 1'b1;
        end else if (cls_a == OPC_QNAN) begin
            value = (cls_b == OPC_QNAN) ? a : b;
        end else if (cls_b == OPC_QNAN) begin
            value = a;
        end else begin
            value = take_b ? b : a;
        end
    end

endmodule

// File: rtl/fp_range_sign.sv
module fp_range_sign
    import fp_range_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] value,
    input  sign_mode_t   mode,
    input  logic         src1_sign,
    input  logic         enable,
    output logic [W-1:0] out
);
    logic new_sign;

    always_comb begin
        unique case (mode)
            SGN_SRC1:  new_sign = src1_sign;
            SGN_KEEP:  new_sign = value[W-1];
            SGN_CLEAR: new_sign = 1'b0;
            SGN_SET:   new_sign = 1'b1;
            default:   new_sign = value[W-1];
        endcase
    end

    assign out = enable ? {new_sign, value[W-2:0]} : value;

endmodule

// File: rtl/fp_range_unit.sv
module fp_range_unit
    import fp_range_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [3:0]           ctl,
    input  logic                 daz,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 flag_invalid,
    output logic                 flag_denormal
);
    localparam int W = 1 + EXP_W + MAN_W;

    opclass_t     cls_a, cls_b;
    logic         den_a, den_b, pick_inv;
    logic [W-1:0] eff_a, eff_b, picked, signed_val;

    fp_operand_prep #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_prep_a (
        .op(op_a), .daz(daz), .cls(cls_a), .denorm(den_a), .eff(eff_a)
    );

    fp_operand_prep #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_prep_b (
        .op(op_b), .daz(daz), .cls(cls_b), .denorm(den_b), .eff(eff_b)
    );

    fp_range_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
        .a(eff_a), .b(eff_b), .cls_a(cls_a), .cls_b(cls_b),
        .mode(cmp_mode_t'(ctl[1:0])), .value(picked), .invalid(pick_inv)
    );

    fp_range_sign #(.W(W)) u_sign (
        .value(picked), .mode(sign_mode_t'(ctl[3:2])), .src1_sign(op_a[W-1]),
        .enable(!pick_inv), .out(signed_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            result        <= '0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result        <= signed_val;
                flag_invalid  <= pick_inv;
                flag_denormal <= den_a | den_b;
            end
        end
    end

endmodule

// File: rtl/fp_range_unit_checker.sv
module fp_range_unit_checker #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic [3:0]           ctl,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] result,
    input logic                 flag_invalid,
    input logic                 flag_denormal
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic a_sig, b_sig, any_sig, any_den;

    assign a_sig   = (&op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0]) && !op_a[MAN_W-1];
    assign b_sig   = (&op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]) && !op_b[MAN_W-1];
    assign any_sig = a_sig || b_sig;
    assign any_den = ((~|op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0])) ||
                     ((~|op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && result == '0 && !flag_invalid && !flag_denormal));

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_denormal)));

    a_r5_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_sig) |=> flag_invalid);

    a_r5_quiet_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> ((&result[W-2:MAN_W]) && result[MAN_W-1]));

    a_r6_no_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_sig) |=> !flag_invalid);

    a_r4_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_sig && ctl[3:2] == 2'b10) |=> !result[W-1]);

    a_r4_sign_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_sig && ctl[3:2] == 2'b11) |=> result[W-1]);

    a_r10_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_denormal == $past(any_den)));

endmodule

bind fp_range_unit fp_range_unit_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ctl(ctl), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
);

// File: tb/fp_range_unit_bench.sv
`timescale 1ns/1ps
module fp_range_unit_bench;
    localparam int SE = 3;
    localparam int SM = 2;
    localparam int SW = 1 + SE + SM;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          s_vld, s_daz, s_ovld, s_inv, s_den;
    logic [SW-1:0] s_a, s_b, s_res;
    logic [3:0]    s_ctl;

    logic          w_vld, w_daz, w_ovld, w_inv, w_den;
    logic [63:0]   w_a, w_b, w_res;
    logic [3:0]    w_ctl;

    int n_chk = 0;
    int n_bad = 0;

    fp_range_unit #(.EXP_W(SE), .MAN_W(SM)) u_fp_range_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(s_vld), .op_a(s_a), .op_b(s_b),
        .ctl(s_ctl), .daz(s_daz), .out_valid(s_ovld), .result(s_res),
        .flag_invalid(s_inv), .flag_denormal(s_den)
    );

    fp_range_unit u_fp_range_unit_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(w_vld), .op_a(w_a), .op_b(w_b),
        .ctl(w_ctl), .daz(w_daz), .out_valid(w_ovld), .result(w_res),
        .flag_invalid(w_inv), .flag_denormal(w_den)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Integer magnitude of a 6-bit operand; infinity above every finite value
    function automatic int mag6(input logic [SW-1:0] x);
        if (x[4:2] == 3'd7) return 1000;
        if (x[4:2] == 3'd0) return int'(x[1:0]);
        return (4 + int'(x[1:0])) << (int'(x[4:2]) - 1);
    endfunction

    function automatic bit is_nan6(input logic [SW-1:0] x);
        return x[4:2] == 3'd7 && x[1:0] != 2'd0;
    endfunction

    function automatic bit is_den6(input logic [SW-1:0] x);
        return x[4:2] == 3'd0 && x[1:0] != 2'd0;
    endfunction

    task automatic ref6(input logic [SW-1:0] a, input logic [SW-1:0] b,
                        input logic [3:0] c, input logic daz,
                        output logic [SW-1:0] r, output logic inv, output string tag);
        logic [SW-1:0] ea, eb, pre;
        int ma, mb, va, vb;
        bit pick_b;
        ea = (daz && is_den6(a)) ? {a[5], 5'b0} : a;
        eb = (daz && is_den6(b)) ? {b[5], 5'b0} : b;
        inv = 1'b0;
        tag = "R3 R4";
        if (daz && (is_den6(a) || is_den6(b))) tag = "R9";
        if (is_nan6(a) && !a[1]) begin
            r = a | 6'b000010; inv = 1'b1; tag = "R5"; return;
        end
        if (is_nan6(b) && !b[1]) begin
            r = b | 6'b000010; inv = 1'b1; tag = "R5"; return;
        end
        if (is_nan6(a)) begin
            pre = is_nan6(b) ? a : eb; tag = "R6";
        end else if (is_nan6(b)) begin
            pre = ea; tag = "R6";
        end else begin
            ma = mag6(ea); mb = mag6(eb);
            va = ea[5] ? -ma : ma;
            vb = eb[5] ? -mb : mb;
            if (ma == mb && ea[5] != eb[5])
                tag = (ma == 0) ? "R7" : "R8";
            unique case (c[1:0])
                2'd0: pick_b = (vb < va) || (vb == va && eb[5] && !ea[5]);
                2'd1: pick_b = (vb > va) || (vb == va && !eb[5] && ea[5]);
                2'd2: pick_b = (mb < ma) || (mb == ma && eb[5] && !ea[5]);
                default: pick_b = (mb > ma) || (mb == ma && !eb[5] && ea[5]);
            endcase
            pre = pick_b ? eb : ea;
        end
        unique case (c[3:2])
            2'd0: r = {a[5], pre[4:0]};
            2'd1: r = pre;
            2'd2: r = {1'b0, pre[4:0]};
            default: r = {1'b1, pre[4:0]};
        endcase
    endtask

    task automatic wide_clamp(input real av, input real expv);
        @(negedge clk);
        w_vld = 1'b1; w_ctl = 4'h2; w_a = $realtobits(av); w_b = $realtobits(1023.0);
        @(negedge clk);
        check(w_ovld && w_res == $realtobits(expv) && !w_inv, "R11 clamp",
              w_res, $realtobits(expv));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [SW-1:0] er;
        logic          ei;
        string         tg;
        rst_n = 1'b0;
        s_vld = 1'b0; s_daz = 1'b0; s_a = '0; s_b = '0; s_ctl = '0;
        w_vld = 1'b0; w_daz = 1'b0; w_a = '0; w_b = '0; w_ctl = '0;
        repeat (3) @(negedge clk);
        check(!s_ovld && s_res == '0 && !s_inv && !s_den, "R1 reset state",
              {s_ovld, s_inv, s_den, s_res}, 64'h0);
        check(!w_ovld && w_res == '0 && !w_inv && !w_den, "R1 reset state wide",
              w_res, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Exhaustive sweep of the small format
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 16; c++) begin
                for (int a = 0; a < 64; a++) begin
                    for (int b = 0; b < 64; b++) begin
                        s_vld = 1'b1; s_daz = d[0]; s_ctl = c[3:0];
                        s_a = a[5:0]; s_b = b[5:0];
                        ref6(a[5:0], b[5:0], c[3:0], d[0], er, ei, tg);
                        @(negedge clk);
                        check(s_ovld && s_res == er && s_inv == ei, tg,
                              {s_inv, s_res}, {ei, er});
                        check(s_den == (is_den6(a[5:0]) || is_den6(b[5:0])), "R10",
                              s_den, is_den6(a[5:0]) || is_den6(b[5:0]));
                    end
                end
            end
        end

        // Hold with in_valid low
        s_vld = 1'b1; s_ctl = 4'h1; s_daz = 1'b0; s_a = 6'b000101; s_b = 6'b001001;
        @(negedge clk);
        er = s_res;
        check(s_ovld && er == 6'b001001, "R2 load", s_res, 6'b001001);
        s_vld = 1'b0; s_a = 6'b011111; s_b = 6'b000001;
        @(negedge clk);
        check(!s_ovld && s_res == er && !s_inv && !s_den, "R2 hold", s_res, er);
        @(negedge clk);
        check(!s_ovld && s_res == er, "R2 hold second cycle", s_res, er);

        // Clamp to +-1023 in double precision
        wide_clamp(5.5, 5.5);
        wide_clamp(-7.25, -7.25);
        wide_clamp(-2000.0, -1023.0);
        wide_clamp(3000.0, 1023.0);
        wide_clamp(1023.0, 1023.0);
        wide_clamp(-1023.0, -1023.0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule